// File: doc/BRIEF.md
# Power-Up Reset Release Sequencer

This block controls when a system reset is released after power is applied. It reads three asynchronous flags: the supply is above the power-on level, the supply is above the brown-out level, and the oscillator is running. Each flag goes through a two-flop synchronizer. A synchronous state machine then walks a fixed chain of dependent delays. The chain is a power-on hold, then a brown-out hold, then a power-up timer. At that point the system reset falls and the oscillator is enabled. The chain continues with an oscillator start-up count and an optional PLL lock wait. The core is then given a one-cycle strobe to begin fetching at address zero. Last, after a separate delay, the clock monitor is enabled.

Each delay is a cycle-count parameter, and every stage shares one counter. A static select input decides whether the PLL lock stage is part of the chain. The current stage is exported as a 3-bit code that can serve as a reset-cause status. Losing the brown-out flag sends the chain back to the brown-out hold. Losing the power-on flag sends it back to the start.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `rst_n` is low: `sys_rst`=1, `osc_en`=0, `fetch_go`=0, `mon_en`=0, `seq_state`=0.
- R2: Each asynchronous flag is seen by the sequencer two clock edges after it changes. From the flags being high to `sys_rst` falling takes P_POR+P_BOR+P_PWRT+5 cycles.
- R3: Code 0 (power-on hold) is held while the power-on flag is low. Once the flag is high, the stage lasts P_POR+1 cycles and then moves to code 1.
- R4: Code 1 (brown-out hold) is held while the brown-out flag is low. Once the flag is high, the stage lasts P_BOR+1 cycles and then moves to code 2.
- R5: Code 2 (power-up timer) lasts P_PWRT+1 cycles. `sys_rst` is 1 in codes 0 to 2 and falls only when the sequencer leaves code 2.
- R6: `osc_en` is 1 exactly in codes 3 to 6, that is, from the cycle `sys_rst` falls.
- R7: Code 3 (oscillator start) waits for the oscillator-ready flag and then lasts P_OST+1 cycles. It moves next to code 4 when `pll_sel`=1 and to code 5 when `pll_sel`=0, so code 4 never occurs when `pll_sel`=0.
- R8: Code 4 (PLL lock) lasts P_LOCK+1 cycles and then moves to code 5.
- R9: `fetch_go` is a single-cycle pulse in the first cycle of code 5. It occurs once per release and only directly after code 3 or code 4.
- R10: Code 5 lasts P_MON+1 cycles and then moves to code 6. `mon_en` is 1 only in code 6 and only while `mon_cfg_en`=1.
- R11: A low brown-out flag in any code from 1 to 6 returns the sequencer to code 1 with the counter cleared and `sys_rst` reasserted. This takes priority over a stage that expires in the same cycle.
- R12: A low power-on flag in any code returns the sequencer to code 0 with the counter cleared.
- R13: A delay parameter of zero makes its stage last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| por_ok_a | input | 1 | Supply above power-on level (asynchronous) |
| bor_ok_a | input | 1 | Supply above brown-out level (asynchronous) |
| osc_rdy_a | input | 1 | Oscillator running (asynchronous) |
| pll_sel | input | 1 | 1: include the PLL lock stage |
| mon_cfg_en | input | 1 | 1: clock monitor permitted |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 1 | Oscillator enable |
| fetch_go | output | 1 | One-cycle strobe: core may fetch from address zero |
| mon_en | output | 1 | Clock monitor enable |
| seq_state | output | 3 | Current stage code (0 to 6) |

## Verification
A stage can expire in the same cycle that a brown-out loss first reaches the sequencer. The two are competing transitions. The bench lowers the brown-out flag two edges before the power-up timer would expire, so the synchronized loss lands on exactly the expiring edge. It then requires code 1 with `sys_rst` never having fallen. A second instance with all delays set to zero checks that one-cycle stages still release in the predicted number of cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_BOR  = 3'd1,
    ST_PWRT = 3'd2,
    ST_OSC  = 3'd3,
    ST_LOCK = 3'd4,
    ST_RUN  = 3'd5,
    ST_MON  = 3'd6
  } seq_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned top);
    int unsigned w;
    w = 1;
    while ((top >> w) != 0) w++;
    return w;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q_s
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d_a;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_s = pipe[STAGES-1];

endmodule

// File: rtl/pwrseq_stage_timer.sv
module pwrseq_stage_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == limit);

  // The count never runs past the limit of the stage it is timing (R13: zero stays zero)
  assert_cnt_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned CW     = 4,
  parameter logic [CW-1:0] L_POR  = '0,
  parameter logic [CW-1:0] L_BOR  = '0,
  parameter logic [CW-1:0] L_PWRT = '0,
  parameter logic [CW-1:0] L_OST  = '0,
  parameter logic [CW-1:0] L_LOCK = '0,
  parameter logic [CW-1:0] L_MON  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_s,
  input  logic          bor_s,
  input  logic          osc_s,
  input  logic          pll_sel,
  input  logic          mon_cfg_en,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic [CW-1:0] tmr_limit,
  output logic          sys_rst,
  output logic          osc_en,
  output logic          fetch_go,
  output logic          mon_en,
  output logic [2:0]    seq_state
);

  seq_st_e st_q, st_d;
  logic    rst_q, oen_q, fetch_q, mon_q;

  // Next-state and counter control
  always_comb begin
    st_d    = st_q;
    tmr_clr = 1'b0;
    tmr_inc = 1'b0;
    if (!por_s) begin
      st_d    = ST_POR;
      tmr_clr = 1'b1;
    end else if (!bor_s && (st_q != ST_POR)) begin
      st_d    = ST_BOR;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_POR: begin
          if (tmr_done) begin st_d = ST_BOR; tmr_clr = 1'b1; end
          else tmr_inc = 1'b1;
        end
        ST_BOR: begin
          if (tmr_done) begin st_d = ST_PWRT; tmr_clr = 1'b1; end
          else tmr_inc = 1'b1;
        end
        ST_PWRT: begin
          if (tmr_done) begin st_d = ST_OSC; tmr_clr = 1'b1; end
          else tmr_inc = 1'b1;
        end
        ST_OSC: begin
          if (!osc_s) tmr_clr = 1'b1;
          else if (tmr_done) begin
            st_d    = pll_sel ? ST_LOCK : ST_RUN;
            tmr_clr = 1'b1;
          end else tmr_inc = 1'b1;
        end
        ST_LOCK: begin
          if (tmr_done) begin st_d = ST_RUN; tmr_clr = 1'b1; end
          else tmr_inc = 1'b1;
        end
        ST_RUN: begin
          if (tmr_done) begin st_d = ST_MON; tmr_clr = 1'b1; end
          else tmr_inc = 1'b1;
        end
        ST_MON:  tmr_clr = 1'b1;
        default: begin st_d = ST_POR; tmr_clr = 1'b1; end
      endcase
    end
  end

  // Limit of the stage being timed
  always_comb begin
    unique case (st_q)
      ST_POR:  tmr_limit = L_POR;
      ST_BOR:  tmr_limit = L_BOR;
      ST_PWRT: tmr_limit = L_PWRT;
      ST_OSC:  tmr_limit = L_OST;
      ST_LOCK: tmr_limit = L_LOCK;
      ST_RUN:  tmr_limit = L_MON;
      default: tmr_limit = '0;
    endcase
  end

  // State and registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_POR;
      rst_q   <= 1'b1;
      oen_q   <= 1'b0;
      fetch_q <= 1'b0;
      mon_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rst_q   <= (st_d == ST_POR) || (st_d == ST_BOR) || (st_d == ST_PWRT);
      oen_q   <= !((st_d == ST_POR) || (st_d == ST_BOR) || (st_d == ST_PWRT));
      fetch_q <= (st_d == ST_RUN) && (st_q != ST_RUN);
      mon_q   <= (st_d == ST_MON) && mon_cfg_en;
    end
  end

  assign sys_rst   = rst_q;
  assign osc_en    = oen_q;
  assign fetch_go  = fetch_q;
  assign mon_en    = mon_q;
  assign seq_state = st_q;

  assert_por_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !por_s |=> (st_q == ST_POR) && sys_rst);

  assert_bor_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (por_s && !bor_s && (st_q != ST_POR)) |=> (st_q == ST_BOR) && sys_rst);

  assert_rst_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> ($past(st_q) == ST_PWRT));

  assert_fetch_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);

  assert_fetch_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> (($past(st_q) == ST_OSC) || ($past(st_q) == ST_LOCK)));

  assert_lock_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |-> (($past(st_q) == ST_LOCK) || ($past(st_q) == ST_OSC)));

  assert_mon_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> (st_q == ST_MON));

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned P_POR  = 15,
  parameter int unsigned P_BOR  = 15,
  parameter int unsigned P_PWRT = 1023,
  parameter int unsigned P_OST  = 1023,
  parameter int unsigned P_LOCK = 255,
  parameter int unsigned P_MON  = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok_a,
  input  logic       bor_ok_a,
  input  logic       osc_rdy_a,
  input  logic       pll_sel,
  input  logic       mon_cfg_en,
  output logic       sys_rst,
  output logic       osc_en,
  output logic       fetch_go,
  output logic       mon_en,
  output logic [2:0] seq_state
);

  localparam int unsigned MAXC = max2(max2(max2(P_POR, P_BOR), max2(P_PWRT, P_OST)),
                                      max2(P_LOCK, P_MON));
  localparam int unsigned CW   = cnt_width(MAXC);

  logic [2:0]    flags_s;
  logic          tmr_clr, tmr_inc, tmr_done;
  logic [CW-1:0] tmr_limit;

  pwrseq_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_a   ({osc_rdy_a, bor_ok_a, por_ok_a}),
    .q_s   (flags_s)
  );

  pwrseq_stage_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .inc   (tmr_inc),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  pwrseq_fsm #(
    .CW     (CW),
    .L_POR  (CW'(P_POR)),
    .L_BOR  (CW'(P_BOR)),
    .L_PWRT (CW'(P_PWRT)),
    .L_OST  (CW'(P_OST)),
    .L_LOCK (CW'(P_LOCK)),
    .L_MON  (CW'(P_MON))
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_s      (flags_s[0]),
    .bor_s      (flags_s[1]),
    .osc_s      (flags_s[2]),
    .pll_sel    (pll_sel),
    .mon_cfg_en (mon_cfg_en),
    .tmr_done   (tmr_done),
    .tmr_clr    (tmr_clr),
    .tmr_inc    (tmr_inc),
    .tmr_limit  (tmr_limit),
    .sys_rst    (sys_rst),
    .osc_en     (osc_en),
    .fetch_go   (fetch_go),
    .mon_en     (mon_en),
    .seq_state  (seq_state)
  );

  assert_osc_vs_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en == !sys_rst);

endmodule

// File: tb/tb_pwrup_rst_seq.sv
module tb_pwrup_rst_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic por_a, bor_a, osc_a, pll, fen;
  logic       sys_rst, osc_en, fetch_go, mon_en;
  logic [2:0] st;
  logic       sys_rst0, osc_en0, fetch_go0, mon_en0;
  logic [2:0] st0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  pwrup_rst_seq #(.P_POR(3), .P_BOR(4), .P_PWRT(5), .P_OST(2), .P_LOCK(6), .P_MON(3)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok_a(por_a), .bor_ok_a(bor_a), .osc_rdy_a(osc_a),
    .pll_sel(pll), .mon_cfg_en(fen), .sys_rst(sys_rst), .osc_en(osc_en),
    .fetch_go(fetch_go), .mon_en(mon_en), .seq_state(st));

  pwrup_rst_seq #(.P_POR(0), .P_BOR(0), .P_PWRT(0), .P_OST(0), .P_LOCK(0), .P_MON(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .por_ok_a(por_a), .bor_ok_a(bor_a), .osc_rdy_a(osc_a),
    .pll_sel(pll), .mon_cfg_en(fen), .sys_rst(sys_rst0), .osc_en(osc_en0),
    .fetch_go(fetch_go0), .mon_en(mon_en0), .seq_state(st0));

  typedef struct packed {
    logic       por, bor, osc, pll, fen;
    logic [5:0] wt;
    logic [2:0] st;
    logic       rst, oen, mon;
    logic [3:0] tag;
  } vec_t;

  // Edge offsets assume P_POR=3, P_BOR=4, P_PWRT=5, P_OST=2, P_LOCK=6, P_MON=3
  localparam vec_t VECS [11] = '{
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 6'd4, 3'd0, 1'b1,1'b0,1'b0, 4'd3},
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 6'd4, 3'd1, 1'b1,1'b0,1'b0, 4'd4},
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 6'd5, 3'd2, 1'b1,1'b0,1'b0, 4'd5},
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 6'd6, 3'd3, 1'b0,1'b1,1'b0, 4'd7},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 6'd2, 3'd3, 1'b0,1'b1,1'b0, 4'd7},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 6'd5, 3'd4, 1'b0,1'b1,1'b0, 4'd8},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 6'd7, 3'd5, 1'b0,1'b1,1'b0, 4'd9},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 6'd4, 3'd6, 1'b0,1'b1,1'b1, 4'd10},
    '{1'b1,1'b0,1'b1,1'b1,1'b1, 6'd3, 3'd1, 1'b1,1'b0,1'b0, 4'd11},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 6'd3, 3'd1, 1'b1,1'b0,1'b0, 4'd11},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 6'd3, 3'd0, 1'b1,1'b0,1'b0, 4'd12}
  };

  function automatic string rtag(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    por_a = 1'b0; bor_a = 1'b0; osc_a = 1'b0; pll = 1'b1; fen = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values held while reset is low
    chk("R1", "sys_rst", int'(sys_rst), 1);
    chk("R1", "osc_en", int'(osc_en), 0);
    chk("R1", "fetch_go", int'(fetch_go), 0);
    chk("R1", "mon_en", int'(mon_en), 0);
    chk("R1", "seq_state", int'(st), 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rel, rel0, nfetch, nfetch0, prev;
    logic saw_lock, rst_low;

    // Table walk: full release with PLL, then brown-out and power-on losses
    do_reset();
    for (int i = 0; i < 11; i++) begin
      por_a = VECS[i].por; bor_a = VECS[i].bor; osc_a = VECS[i].osc;
      pll = VECS[i].pll; fen = VECS[i].fen;
      repeat (int'(VECS[i].wt)) @(posedge clk);
      @(negedge clk);
      chk(rtag(VECS[i].tag), "seq_state", int'(st), int'(VECS[i].st));
      chk(rtag(VECS[i].tag), "sys_rst", int'(sys_rst), int'(VECS[i].rst));
      chk("R6", "osc_en", int'(osc_en), int'(VECS[i].oen));
      chk(rtag(VECS[i].tag), "mon_en", int'(mon_en), int'(VECS[i].mon));
      chk("R9", "fetch_go idle", int'(fetch_go), 0);
    end

    // R2 / R5 / R13: release latency, nominal and all-zero delays
    do_reset();
    por_a = 1'b1; bor_a = 1'b1;
    rel = -1; rel0 = -1;
    for (int e = 1; e <= 30; e++) begin
      @(posedge clk); @(negedge clk);
      if (rel  < 0 && !sys_rst)  rel  = e;
      if (rel0 < 0 && !sys_rst0) rel0 = e;
    end
    chk("R2", "release edges", rel, 3 + 4 + 5 + 5);
    chk("R13", "zero-delay release edges", rel0, 5);

    // R7 / R9 / R10 / R13: no PLL, monitor disabled
    do_reset();
    por_a = 1'b1; bor_a = 1'b1; osc_a = 1'b1; pll = 1'b0; fen = 1'b0;
    nfetch = 0; nfetch0 = 0; saw_lock = 1'b0; prev = 0;
    for (int e = 1; e <= 40; e++) begin
      @(posedge clk); @(negedge clk);
      if (st == 3'd4 || st0 == 3'd4) saw_lock = 1'b1;
      if (fetch_go) begin
        nfetch++;
        chk("R9", "state at fetch", int'(st), 5);
        chk("R9", "state before fetch", prev, 3);
      end
      if (fetch_go0) nfetch0++;
      if (st == 3'd6) chk("R10", "mon_en with monitor off", int'(mon_en), 0);
      prev = int'(st);
    end
    chk("R7", "lock stage seen without PLL", int'(saw_lock), 0);
    chk("R9", "fetch pulses", nfetch, 1);
    chk("R13", "zero-delay fetch pulses", nfetch0, 1);
    chk("R10", "final state", int'(st), 6);
    chk("R13", "zero-delay final state", int'(st0), 6);

    // R11: brown-out loss arriving on the edge the power-up timer expires
    do_reset();
    por_a = 1'b1; bor_a = 1'b1;
    rst_low = 1'b0;
    for (int e = 1; e <= 14; e++) begin
      @(posedge clk); @(negedge clk);
      if (!sys_rst) rst_low = 1'b1;
    end
    bor_a = 1'b0;
    for (int e = 15; e <= 17; e++) begin
      @(posedge clk); @(negedge clk);
      if (!sys_rst) rst_low = 1'b1;
    end
    chk("R11", "state after collision", int'(st), 1);
    chk("R11", "sys_rst ever released", int'(rst_low), 0);
    chk("R11", "osc_en after collision", int'(osc_en), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule